// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is a single timer channel. Software programs a start count and a control word, and the channel then counts down. Each step of the count happens after a programmable number of reference clocks. When the count runs out, the channel raises a pending flag. In periodic mode it reloads the start count and carries on. In one-shot mode it stops and drops its enable.

A level interrupt follows the pending flag, gated by an interrupt-enable bit. Software can stop the channel at any moment, and the count it had reached is kept. Enabling the channel again resumes from that count. A reload bit in the control word copies the start count into the counter, and it never reads back as set.

The block has a plain synchronous write port that selects either the control word or the start count. The control word, the start count and the live count are brought out directly. A one-cycle clear input is driven by the shared write-one-to-clear status register that sits outside the channel. Address decode across several channels and the bus protocol belong to the surrounding logic.

Top module: `tmr_channel`

## Requirements
- R1: Control word layout: bit 30 enable, bit 29 interrupt enable, bit 27 periodic mode, bit 26 reload, bit 25 running flag, bits 7:0 prescale N. The reload bit and all other bits read as 0.
- R2: Bits 24:8 and the running flag (bit 25) are ignored on a control write.
- R3: The running flag is set by a control write that takes enable from 0 to 1. It is cleared whenever enable goes to 0, whether by a write or by a one-shot stop.
- R4: A control write with bit 26 set copies the start count into the live count. If the same write also sets bit 30, the enable is dropped and the channel stays stopped.
- R5: While enabled, the live count K drops by one every N+1 clocks. Every write restarts the prescaler phase, so expiry falls on the K*(N+1)-th clock edge after the enabling write (K of 0 behaves as 1).
- R6: On expiry in one-shot mode (bit 27 = 0), the pending flag is set, the live count becomes 0 and both enable and the running flag are cleared.
- R7: On expiry in periodic mode (bit 27 = 1), the pending flag is set, the live count reloads the start count and the channel keeps running.
- R8: irq_o is high exactly when interrupt enable and the pending flag are both set, from the edge on which either one changes. A pend_clr pulse clears the pending flag.
- R9: After reset, the control word reads 0x00000005, and the start count, live count, pending flag and irq_o are all 0.
- R10: A write to the start count also loads the live count with the new value on the same edge.
- R11: Clearing enable freezes the live count, and setting enable again resumes from the frozen value. A change of prescale while running leaves the live count unchanged.
- R12: While the channel is disabled, no pending event is ever raised, including when it has stopped at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 start count |
| wr_data | input | 32 | Write data |
| pend_clr | input | 1 | One-cycle clear of the pending flag |
| ctrl_rd | output | 32 | Control word readback |
| init_rd | output | CNT_W | Start count readback |
| count_rd | output | CNT_W | Live count (read-only) |
| pend_o | output | 1 | Pending flag |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench attacks five corner cases.

- **Reload plus enable in one write.** A design that kept the enable would start counting and raise a pending event that should never come.
- **Disable mid-count and re-enable.** A design that reloaded on resume, or kept counting while stopped, would show the wrong live count.
- **Prescale change while running.** A design that rescaled or reset the count would break the count value read just after the write.
- **Pending set with interrupts masked.** A design that latched the interrupt itself, instead of gating the flag, would fail the check that irq_o follows a late interrupt-enable write and a later clear.
- **Reserved and running-flag bits written as ones.** A design that stored them would read back a wrong control word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PS_W  = 8;
  localparam int B_EN  = 30;
  localparam int B_IE  = 29;
  localparam int B_PER = 27;
  localparam int B_RLD = 26;
  localparam int B_ACT = 25;

  typedef struct packed {
    logic            en;
    logic            ie;
    logic            per;
    logic            act;
    logic [PS_W-1:0] ps;
  } ctrl_t;

  // New control state after a software write; reserved and running-flag bits are dropped.
  function automatic ctrl_t ctrl_apply(input logic [31:0] w, input ctrl_t old);
    ctrl_t n;
    n.en  = w[B_EN] & ~w[B_RLD];
    n.ie  = w[B_IE];
    n.per = w[B_PER];
    n.ps  = w[PS_W-1:0];
    if (!n.en)       n.act = 1'b0;
    else if (!old.en) n.act = 1'b1;
    else             n.act = old.act;
    return n;
  endfunction

  function automatic logic [31:0] ctrl_pack(input ctrl_t c);
    logic [31:0] r;
    r = '0;
    r[B_EN]     = c.en;
    r[B_IE]     = c.ie;
    r[B_PER]    = c.per;
    r[B_ACT]    = c.act;
    r[PS_W-1:0] = c.ps;
    return r;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] div,
  output logic            tick
);
  logic [PS_W-1:0] ph_q;

  function automatic logic phase_done(input logic [PS_W-1:0] ph, input logic [PS_W-1:0] d);
    return ph >= d;
  endfunction

  assign tick = run & ~restart & phase_done(ph_q, div);

  always_ff @(posedge clk) begin
    if (!rst_n)       ph_q <= '0;
    else if (restart) ph_q <= '0;
    else if (run)     ph_q <= tick ? '0 : ph_q + 1'b1;
  end

  // R5: with a divider above zero, two ticks never come back to back
  a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
  // R5: a write cycle never advances the count
  a_r5_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             periodic,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);
  function automatic logic last_step(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] after_tick(input logic [CNT_W-1:0] c,
                                                  input logic per,
                                                  input logic [CNT_W-1:0] rv);
    if (last_step(c)) return per ? rv : '0;
    return c - 1'b1;
  endfunction

  assign expire = tick & ~load & last_step(count_q);

  always_ff @(posedge clk) begin
    if (!rst_n)    count_q <= '0;
    else if (load) count_q <= load_val;
    else if (tick) count_q <= after_tick(count_q, periodic, reload_val);
  end

  // R7: periodic expiry restores the start count
  a_r7_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> count_q == $past(reload_val));
  // R6: one-shot expiry leaves the count at zero
  a_r6_oneshot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic) |=> count_q == '0);
  // R11: without a step or a load the count is frozen
  a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count_q));
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
#(
  parameter logic [PS_W-1:0] RST_PS = 8'd5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic [31:0] wdata,
  input  logic        stop_req,
  output ctrl_t       c_q,
  output logic        reload_req
);
  assign reload_req = wr_ctrl & wdata[B_RLD];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q <= '{en: 1'b0, ie: 1'b0, per: 1'b0, act: 1'b0, ps: RST_PS};
    end else if (wr_ctrl) begin
      c_q <= ctrl_apply(wdata, c_q);
    end else if (stop_req) begin
      c_q.en  <= 1'b0;
      c_q.act <= 1'b0;
    end
  end

  // R4: a reload write never leaves the channel enabled
  a_r4_reload_drops_en: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> !c_q.en);
  // R3: enabling raises the running flag together with enable
  a_r3_act_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_q.en) |-> c_q.act);
  // R3: without enable the running flag is low
  a_r3_act_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    !c_q.en |-> !c_q.act);
  // R6: a one-shot stop clears enable and running flag
  a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !wr_ctrl) |=> (!c_q.en && !c_q.act));
  // R2: writing the running flag alone cannot set it
  a_r2_act_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[B_ACT] && !wdata[B_EN]) |=> !c_q.act);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [PS_W-1:0] RST_PS = 8'd5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             pend_clr,
  output logic [31:0]      ctrl_rd,
  output logic [CNT_W-1:0] init_rd,
  output logic [CNT_W-1:0] count_rd,
  output logic             pend_o,
  output logic             irq_o
);
  logic             wr_ctrl, wr_init, reload_req, tick, expire, stop_req, load;
  logic [CNT_W-1:0] init_q, load_val;
  logic             pend_q;
  ctrl_t            c_q;

  assign wr_ctrl  = wr_en & ~wr_sel;
  assign wr_init  = wr_en & wr_sel;
  assign load     = wr_init | reload_req;
  assign load_val = wr_init ? wr_data[CNT_W-1:0] : init_q;
  assign stop_req = expire & ~c_q.per;

  tmr_ctrl_reg #(.RST_PS(RST_PS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(wr_data),
    .stop_req(stop_req), .c_q(c_q), .reload_req(reload_req)
  );

  tmr_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .run(c_q.en), .restart(wr_en),
    .div(c_q.ps), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .load_val(load_val),
    .periodic(c_q.per), .reload_val(init_q), .count_q(count_rd), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       init_q <= '0;
    else if (wr_init) init_q <= wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (expire)   pend_q <= 1'b1;
    else if (pend_clr) pend_q <= 1'b0;
  end

  assign ctrl_rd = ctrl_pack(c_q);
  assign init_rd = init_q;
  assign pend_o  = pend_q;
  assign irq_o   = c_q.ie & pend_q;

  // R8: expiry always leaves the pending flag set
  a_r8_pend_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend_o);
  // R8: a clear without a competing expiry empties the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !expire) |=> !pend_o);
  // R10: a start-count write shows up in the live count on the next cycle
  a_r10_init_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_init |=> count_rd == $past(wr_data[CNT_W-1:0]));
  // R12: a disabled channel raises no new pending event
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_q.en && !pend_q) |=> !pend_o);
endmodule

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        pend_clr = 1'b0;
  logic [31:0] ctrl_rd, init_rd, count_rd;
  logic        pend_o, irq_o;
  int total = 0;
  int bad = 0;

  localparam logic [31:0] EN = 32'h4000_0000, IE = 32'h2000_0000,
                          PER = 32'h0800_0000, RLD = 32'h0400_0000,
                          ACT = 32'h0200_0000;

  always #5 clk = ~clk;

  tmr_channel i_tmr_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pend_clr(pend_clr), .ctrl_rd(ctrl_rd), .init_rd(init_rd), .count_rd(count_rd),
    .pend_o(pend_o), .irq_o(irq_o)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    pend_clr = 1'b1;
    @(negedge clk);
    pend_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 ctrl", ctrl_rd, 32'h0000_0005);
    chk("R9 init", init_rd, 0);
    chk("R9 count", count_rd, 0);
    chk("R9 pend", {31'b0, pend_o}, 0);
    chk("R9 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_oneshot();
    wr(1'b1, 4);
    chk("R10 count after init write", count_rd, 4);
    wr(1'b0, EN | IE | 32'd2);
    chk("R1 R3 ctrl after enable", ctrl_rd, EN | IE | ACT | 32'd2);
    idle(11);
    chk("R5 count before expiry", count_rd, 1);
    chk("R5 no early pend", {31'b0, pend_o}, 0);
    idle(1);
    chk("R6 pend at expiry", {31'b0, pend_o}, 1);
    chk("R8 irq at expiry", {31'b0, irq_o}, 1);
    chk("R6 count zero", count_rd, 0);
    chk("R6 R3 ctrl stopped", ctrl_rd, IE | 32'd2);
    idle(10);
    chk("R6 stays at zero", count_rd, 0);
    clr();
    chk("R8 pend cleared", {31'b0, pend_o}, 0);
    chk("R8 irq dropped", {31'b0, irq_o}, 0);
  endtask

  task automatic t_fields();
    wr(1'b0, 32'h0FFF_FF03);
    chk("R2 R1 reserved and flag ignored", ctrl_rd, PER | 32'd3);
    chk("R4 reload copies start count", count_rd, 4);
    wr(1'b0, EN | RLD | 32'd1);
    chk("R4 enable dropped", ctrl_rd, 32'd1);
    idle(20);
    chk("R4 no counting", count_rd, 4);
    chk("R12 no pend while stopped", {31'b0, pend_o}, 0);
  endtask

  task automatic t_periodic();
    wr(1'b1, 3);
    wr(1'b0, EN | PER);
    chk("R3 periodic running flag", ctrl_rd, EN | PER | ACT);
    idle(2);
    chk("R5 periodic count", count_rd, 1);
    chk("R5 periodic no early pend", {31'b0, pend_o}, 0);
    idle(1);
    chk("R7 pend set", {31'b0, pend_o}, 1);
    chk("R7 reloaded", count_rd, 3);
    chk("R7 still running", ctrl_rd, EN | PER | ACT);
    chk("R8 masked irq", {31'b0, irq_o}, 0);
    wr(1'b0, EN | IE | PER);
    chk("R8 irq on late ie", {31'b0, irq_o}, 1);
    clr();
    chk("R8 clear pend", {31'b0, pend_o}, 0);
    chk("R8 irq follows clear", {31'b0, irq_o}, 0);
    chk("R7 keeps counting", count_rd, 2);
    idle(2);
    chk("R7 second expiry", {31'b0, pend_o}, 1);
    chk("R7 second reload", count_rd, 3);
    wr(1'b0, 0);
    clr();
  endtask

  task automatic t_pause();
    wr(1'b1, 10);
    wr(1'b0, EN | 32'd1);
    chk("R3 ctrl enabled", ctrl_rd, EN | ACT | 32'd1);
    idle(6);
    chk("R5 divide by two", count_rd, 7);
    wr(1'b0, 32'd1);
    chk("R3 flag cleared on disable", ctrl_rd, 32'd1);
    idle(20);
    chk("R11 frozen", count_rd, 7);
    wr(1'b0, EN | 32'd1);
    chk("R11 resume keeps count", count_rd, 7);
    idle(2);
    chk("R11 resumed step", count_rd, 6);
    wr(1'b0, EN | 32'd4);
    chk("R11 prescale change keeps count", count_rd, 6);
    idle(4);
    chk("R5 new prescale no early step", count_rd, 6);
    idle(1);
    chk("R5 new prescale step", count_rd, 5);
    wr(1'b1, 2);
    chk("R10 reload while running", count_rd, 2);
    chk("R10 still enabled", ctrl_rd, EN | ACT | 32'd4);
    idle(5);
    chk("R5 step after reload", count_rd, 1);
    chk("R6 no early pend", {31'b0, pend_o}, 0);
    idle(5);
    chk("R6 one-shot pend", {31'b0, pend_o}, 1);
    chk("R6 one-shot ctrl", ctrl_rd, 32'd4);
  endtask

  task automatic t_zero_disable();
    clr();
    wr(1'b0, 32'd4);
    idle(10);
    chk("R12 no event after disable at zero", {31'b0, pend_o}, 0);
    chk("R12 count stays zero", count_rd, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_oneshot();
    t_fields();
    t_periodic();
    t_pause();
    t_zero_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule